// File: doc/BRIEF.md
# Masked Multi-Address I2C Slave Matcher

This block decides whether an I2C slave is being addressed. A bit-level front end, which is not part of this block, delivers START, STOP and one strobe for each sampled bit. The block shifts in the first byte after each START or repeated START. On the eighth bit it compares the seven address bits against four programmable slots and reports the outcome. Each slot holds its own address, its own don't-care mask and a flag that lets it answer the all-zero General Call address.

The result is a one-cycle decision strobe. Along with it the block reports a held "addressed" level, the index of the winning slot, a General Call indicator and the direction bit. Every completed nine-bit frame (eight data bits plus acknowledge) copies its eight data bits into a read-only buffer. A small control register with set-only and clear-only write ports holds the interface enable and the acknowledge, interrupt, stop and start flags. While the enable is low, bus activity has no effect.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, ctl_o, addressed_o, match_stb_o, gc_o and data_buf_o are 0 and all address and mask registers are 0x00. A START followed by address 0000000 therefore gives a decision with no match.
- R2: A write on the set port ORs ctl_wdata_i into the control register. Only bits 2 (ack), 3 (irq), 4 (stop), 5 (start) and 6 (enable) exist. Zeros leave bits unchanged, and bits 1:0 always read 0.
- R3: A write on the clear port clears every defined control bit written as 1. It is the only way to clear the enable bit (bit 6). When both ports are written in the same cycle, the set port wins.
- R4: While the enable bit is 0, start_i, stop_i and bit_valid_i are ignored. No strobe is produced, addressed_o stays 0, data_buf_o is unchanged, and the stop bit (bit 4) reads 0 and cannot be set.
- R5: The decision is made on the eighth bit of the first byte after a START. match_stb_o pulses one cycle later, and rw_o takes the eighth bit, which plays no part in the compare.
- R6: An address register write (cfg_mask_sel_i=0) stores the slot address in bits 7:1 and the General Call enable in bit 0. A mask write (cfg_mask_sel_i=1) stores the mask in bits 7:1. A mask bit of 1 makes that address bit a don't-care, and a zero mask requires an exact match.
- R7: A received address of 0000000 is a General Call. It matches only slots whose General Call enable is set, masks are ignored for it, and gc_o is 1.
- R8: When several slots match, match_slot_o reports the lowest-numbered one.
- R9: Bytes after the first produce no decision. A repeated START without a STOP starts a new decision.
- R10: After the ninth bit of every byte, data_buf_o holds that byte's eight data bits, MSB first on the bus. After only eight bits it still holds the previous byte.
- R11: STOP, a new START, or clearing the enable bit drops addressed_o and gc_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_set_we_i | input | 1 | Write strobe for the set port |
| ctl_clr_we_i | input | 1 | Write strobe for the clear port |
| ctl_wdata_i | input | 7 | Write data for both control ports |
| ctl_o | output | 7 | Control register value |
| cfg_we_i | input | 1 | Slot register write strobe |
| cfg_mask_sel_i | input | 1 | 0 selects the address register, 1 selects the mask register |
| cfg_slot_i | input | 2 | Slot index of the write |
| cfg_wdata_i | input | 8 | Slot register write data |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| bit_valid_i | input | 1 | One-cycle strobe for each sampled bus bit |
| bit_i | input | 1 | Sampled bus bit value |
| match_stb_o | output | 1 | One-cycle pulse when an address decision is made |
| addressed_o | output | 1 | Held high after a match until STOP, START or disable |
| match_slot_o | output | 2 | Index of the winning slot |
| gc_o | output | 1 | The match was a General Call |
| rw_o | output | 1 | Direction bit of the last decided address byte |
| data_buf_o | output | 8 | Last completed received byte |

## Verification
The decision outputs (strobe, addressed level, slot, General Call flag, direction) are registered once. They are due one clock after the eighth bit strobe of an address byte. The buffer is due one clock after the ninth bit strobe, and control writes are visible one clock after the write. The driver holds each input for exactly one cycle starting at a falling edge. The scoreboard monitor samples the strobe and decision outputs at the next falling edge, and direct checks of levels sit at falling edges after the due edge has passed. Checks for "no decision" compare the monitor's strobe count before and after the stimulus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int NSLOT  = 4;
  localparam int AW     = 7;
  localparam int CTL_W  = 7;
  localparam int B_AA   = 2;
  localparam int B_SI   = 3;
  localparam int B_STO  = 4;
  localparam int B_STA  = 5;
  localparam int B_EN   = 6;
  localparam logic [CTL_W-1:0] CTL_DEF =
    CTL_W'((1 << B_AA) | (1 << B_SI) | (1 << B_STO) | (1 << B_STA) | (1 << B_EN));
endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d, wmask;

  assign wmask = wdata_i & CTL_DEF;

  always_comb begin
    ctl_d = ctl_q;
    if (clr_we_i) ctl_d = ctl_d & ~wmask;
    if (set_we_i) ctl_d = ctl_d | wmask;
    ctl_d[B_STO] = ctl_d[B_STO] & ctl_d[B_EN];  // stop flag forced low while disabled
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;

  assign ctl_o = ctl_q;
endmodule

// File: rtl/i2cm_slot_cmp.sv
module i2cm_slot_cmp #(
  parameter int AW = 7
) (
  input  logic [AW:0]   addr_i,   // [AW:1] address, [0] general call enable
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] rx_i,
  output logic          hit_o,
  output logic          gc_hit_o
);
  logic is_gc;
  assign is_gc    = ~|rx_i;
  assign hit_o    = !is_gc && (((rx_i ^ addr_i[AW:1]) & ~mask_i) == '0);
  assign gc_hit_o = is_gc && addr_i[0];
endmodule

// File: rtl/i2cm_prio.sv
module i2cm_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cm_pkg::*;
#(
  parameter int NSlot = i2cm_pkg::NSLOT,
  localparam int SW = (NSlot > 1) ? $clog2(NSlot) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_set_we_i,
  input  logic             ctl_clr_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  input  logic             cfg_we_i,
  input  logic             cfg_mask_sel_i,
  input  logic [SW-1:0]    cfg_slot_i,
  input  logic [AW:0]      cfg_wdata_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             match_stb_o,
  output logic             addressed_o,
  output logic [SW-1:0]    match_slot_o,
  output logic             gc_o,
  output logic             rw_o,
  output logic [AW:0]      data_buf_o
);
  localparam int CW = $clog2(AW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(AW + 1);  // ack position
  localparam logic [CW-1:0] RW_BIT   = CW'(AW);      // direction position

  logic en;
  logic [AW:0]   addr_q [NSlot];
  logic [AW-1:0] mask_q [NSlot];
  logic [NSlot-1:0] hit, gc_hit;
  logic [NSlot-1:0] req;
  logic             found;
  logic [SW-1:0]    idx;

  logic [AW:0]   shift_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          rx_is_gc;

  i2cm_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(ctl_set_we_i),
    .clr_we_i(ctl_clr_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl_o)
  );
  assign en = ctl_o[B_EN];

  for (genvar s = 0; s < NSlot; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[s] <= '0;
        mask_q[s] <= '0;
      end else if (cfg_we_i && cfg_slot_i == SW'(s)) begin
        if (cfg_mask_sel_i) mask_q[s] <= cfg_wdata_i[AW:1];
        else                addr_q[s] <= cfg_wdata_i;
      end
    end

    i2cm_slot_cmp #(.AW(AW)) u_cmp (
      .addr_i  (addr_q[s]),
      .mask_i  (mask_q[s]),
      .rx_i    (shift_q[AW-1:0]),
      .hit_o   (hit[s]),
      .gc_hit_o(gc_hit[s])
    );
  end

  assign rx_is_gc = ~|shift_q[AW-1:0];
  assign req      = rx_is_gc ? gc_hit : hit;

  i2cm_prio #(.N(NSlot)) u_prio (
    .req_i  (req),
    .found_o(found),
    .idx_o  (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q      <= '0;
      cnt_q        <= '0;
      first_q      <= 1'b0;
      data_buf_o   <= '0;
      match_stb_o  <= 1'b0;
      addressed_o  <= 1'b0;
      match_slot_o <= '0;
      gc_o         <= 1'b0;
      rw_o         <= 1'b0;
    end else if (!en) begin
      cnt_q       <= '0;
      first_q     <= 1'b0;
      match_stb_o <= 1'b0;
      addressed_o <= 1'b0;
      gc_o        <= 1'b0;
    end else begin
      match_stb_o <= 1'b0;
      if (start_i) begin
        cnt_q       <= '0;
        first_q     <= 1'b1;
        addressed_o <= 1'b0;
        gc_o        <= 1'b0;
      end else if (stop_i) begin
        cnt_q       <= '0;
        first_q     <= 1'b0;
        addressed_o <= 1'b0;
        gc_o        <= 1'b0;
      end else if (bit_valid_i) begin
        shift_q <= {shift_q[AW-1:0], bit_i};
        if (cnt_q == LAST_BIT) begin
          cnt_q      <= '0;
          first_q    <= 1'b0;
          data_buf_o <= shift_q;  // eight data bits, ack excluded
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (cnt_q == RW_BIT && first_q) begin
          match_stb_o  <= 1'b1;
          addressed_o  <= found;
          match_slot_o <= found ? idx : '0;
          gc_o         <= found && rx_is_gc;
          rw_o         <= bit_i;
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
  import i2cm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_set_we_i,
  input logic             ctl_clr_we_i,
  input logic [CTL_W-1:0] ctl_o,
  input logic             bit_valid_i,
  input logic             match_stb_o,
  input logic             addressed_o,
  input logic             gc_o,
  input logic [7:0]       data_buf_o
);
  localparam logic [CTL_W-1:0] STICKY =
    CTL_W'((1 << B_AA) | (1 << B_SI) | (1 << B_STA) | (1 << B_EN));

  a_r4_no_strobe_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[B_EN] |=> !match_stb_o);

  a_r4_stop_forced_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[B_EN] |-> !ctl_o[B_STO]);

  a_r3_enable_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[B_EN] && !ctl_clr_we_i) |=> ctl_o[B_EN]);

  a_r2_set_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_set_we_i && !ctl_clr_we_i) |=>
      ((ctl_o & $past(ctl_o) & STICKY) == ($past(ctl_o) & STICKY)));

  a_r10_buf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(data_buf_o));

  a_r7_gc_implies_addressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_o |-> addressed_o);
endmodule

bind i2c_addr_matcher i2cm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_set_we_i(ctl_set_we_i),
  .ctl_clr_we_i(ctl_clr_we_i),
  .ctl_o       (ctl_o),
  .bit_valid_i (bit_valid_i),
  .match_stb_o (match_stb_o),
  .addressed_o (addressed_o),
  .gc_o        (gc_o),
  .data_buf_o  (data_buf_o)
);

// File: tb/tb_i2c_addr_matcher.sv
module tb_i2c_addr_matcher;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_set_we_i = 1'b0, ctl_clr_we_i = 1'b0;
  logic [6:0] ctl_wdata_i = '0;
  logic [6:0] ctl_o;
  logic       cfg_we_i = 1'b0, cfg_mask_sel_i = 1'b0;
  logic [1:0] cfg_slot_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic       start_i = 1'b0, stop_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0;
  logic       match_stb_o, addressed_o, gc_o, rw_o;
  logic [1:0] match_slot_o;
  logic [7:0] data_buf_o;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];  // {hit, slot[1:0], gc, rw}

  always #10 clk_i = ~clk_i;  // 50 MHz

  i2c_addr_matcher dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected decision on each strobe
  always @(negedge clk_i) begin
    if (rst_ni && match_stb_o) begin
      stb_cnt++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected decision act=%0h exp=none",
                 {addressed_o, match_slot_o, gc_o, rw_o});
      end else begin
        chk("R5/R6/R7/R8 decision", {27'd0, addressed_o, match_slot_o, gc_o, rw_o},
            {27'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic ctl_set(input logic [6:0] d);
    ctl_set_we_i = 1'b1; ctl_wdata_i = d;
    @(negedge clk_i);
    ctl_set_we_i = 1'b0; ctl_wdata_i = '0;
  endtask

  task automatic ctl_clr(input logic [6:0] d);
    ctl_clr_we_i = 1'b1; ctl_wdata_i = d;
    @(negedge clk_i);
    ctl_clr_we_i = 1'b0; ctl_wdata_i = '0;
  endtask

  task automatic cfg(input logic msel, input logic [1:0] s, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_mask_sel_i = msel; cfg_slot_i = s; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_bit(input logic b);
    bit_valid_i = 1'b1; bit_i = b;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) pulse_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    pulse_bit(1'b0);
  endtask

  task automatic bus_start();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic bus_stop();
    stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic addr_byte(input logic [7:0] b, input logic [4:0] exp);
    exp_q.push_back(exp);
    bus_start();
    send_byte(b);
  endtask

  task automatic finish_run();
    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 ctl", ctl_o, 0);
    chk("R1 addressed", addressed_o, 0);
    chk("R1 buffer", data_buf_o, 0);
    chk("R1 strobe", match_stb_o, 0);

    // R4 disabled: bus ignored, stop flag cannot be set
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hA0);
    chk("R4 no decision when disabled", stb_cnt - s0, 0);
    chk("R4 buffer unchanged when disabled", data_buf_o, 0);
    chk("R4 not addressed when disabled", addressed_o, 0);
    ctl_set(7'h10);
    chk("R4 stop forced low", ctl_o, 0);

    // R2 set-only
    ctl_set(7'h47);
    chk("R2 set enable+ack, reserved read 0", ctl_o, 7'h44);
    ctl_set(7'h00);
    chk("R2 zero write no effect", ctl_o, 7'h44);

    // R1 general call not answered after reset
    addr_byte(8'h00, 5'b0_00_0_0);
    chk("R1 general call ignored", addressed_o, 0);

    // slot setup (R6 field layout)
    cfg(1'b0, 2'd0, 8'hA0);             // 0x50, no gc
    cfg(1'b0, 2'd1, 8'h40); cfg(1'b1, 2'd1, 8'h1E); // 0x20, mask 0x0F
    cfg(1'b0, 2'd2, 8'h43);             // 0x21, gc enabled
    cfg(1'b0, 2'd3, 8'hE0); cfg(1'b1, 2'd3, 8'hFE); // 0x70, mask 0x7F

    // R8: slots 0 and 3 match 0x50
    addr_byte(8'hA0, 5'b1_00_0_0);
    chk("R11 addressed held", addressed_o, 1);
    // R10/R9 data byte
    s0 = stb_cnt;
    send_bits(8'h3C, 8);
    chk("R10 buffer waits for ninth bit", data_buf_o, 8'hA0);
    pulse_bit(1'b0);
    chk("R10 buffer after ninth bit", data_buf_o, 8'h3C);
    chk("R9 no decision on data byte", stb_cnt - s0, 0);
    bus_stop();
    chk("R11 stop clears addressed", addressed_o, 0);

    // R6 masked slot1, read direction
    addr_byte(8'h57, 5'b1_01_0_1);
    // R7 general call bypasses mask of slot3
    addr_byte(8'h00, 5'b1_10_1_0);
    chk("R7 gc level", gc_o, 1);
    // R6 full mask slot3, then R9 repeated start; R8 slot1 before 2,3
    addr_byte(8'h66, 5'b1_11_0_0);
    addr_byte(8'h43, 5'b1_01_0_1);
    chk("R11 start clears gc", gc_o, 0);
    // R6 exact compare miss
    cfg(1'b1, 2'd3, 8'h00);
    addr_byte(8'hA2, 5'b0_00_0_0);
    chk("R6 exact miss not addressed", addressed_o, 0);
    bus_stop();

    // R3/R4/R11 disable via clear port
    addr_byte(8'hA0, 5'b1_00_0_0);
    ctl_set(7'h10);
    chk("R2 stop set while enabled", ctl_o, 7'h54);
    ctl_clr(7'h40);
    chk("R3 enable cleared, stop forced", ctl_o, 7'h04);
    @(negedge clk_i);
    chk("R11 disable clears addressed", addressed_o, 0);
    ctl_clr(7'h04);
    chk("R3 clear ack", ctl_o, 7'h00);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule